// File: doc/BRIEF.md
# PHY Management Frame Master

This block runs the two-wire PHY management port on behalf of software. Software writes one 32-bit management word that holds the whole frame. The word carries the start code, the operation, the PHY and register addresses, the turnaround code and sixteen data bits. The block sends a preamble of 32 ones, then the word MSB first. It changes the data line on the falling edge of the generated management clock. For a read it releases the line at the turnaround and samples the PHY's sixteen reply bits on rising clock edges. It writes those bits back into the low half of the same word.

The management clock runs only during a frame. It is the system clock divided by a ratio picked from a small fixed set. The idle output tells software when the word may be read back or rewritten. The port works only while the management-enable input is high. Dropping that input ends any frame at once.

Top module: `mdio_master`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and mgmt_word is 0.
- R2: A wr_en pulse while idle is 1 and mgmt_en is 1 loads wr_word into mgmt_word at that clock edge and drops idle after the same edge.
- R3: A frame is 64 bit times long. The first 32 bits are ones. The next 32 bits are the accepted word, bit 31 first. Each bit changes on a falling mdc edge and is held across the next rising edge.
- R4: div_sel picks the mdc period N in system clocks: 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, and 6 or 7→96. mdc is high for N/2 clocks and low for N/2 clocks of each period.
- R5: idle returns to 1 exactly 64·N clock edges after the edge that accepted the word.
- R6: A word whose bits [29:28] equal 2'b10 is a read. mdio_oe is 0 from frame bit 14 (the turnaround, bit 46 counted from the start of the preamble) to the end of the frame. The 16 bits sampled on the last 16 rising mdc edges replace mgmt_word[15:0], first-received bit in bit 15. Bits [31:16] are kept.
- R7: Any other value of bits [29:28] is a write. mdio_oe stays 1 for all 64 bits, and mgmt_word is unchanged when the frame ends.
- R8: wr_en while a frame is in progress is ignored. The frame, its timing and its final word are those of the accepted word.
- R9: While mgmt_en is 0, wr_en is ignored. Dropping mgmt_en during a frame aborts it: after the next edge idle is 1, mdc is 0, mdio_oe is 0, and mgmt_word still holds the written word.
- R10: Whenever idle is 1, mdc and mdio_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 3 | Clock ratio select, latched when a word is accepted |
| wr_en | input | 1 | Write strobe for the management word |
| wr_word | input | 32 | Management word to send |
| mgmt_word | output | 32 | Current management word, holding read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
The accepting edge is the reference for timing. idle must already be low at the falling clock that follows it. Its return is counted edge by edge and must come exactly 64·N edges later. mgmt_word is compared at that same sample point.

A PHY model in the bench records mdio_o and mdio_oe on every rising mdc edge. It drives reply bits that change only after a rising edge, so each reply bit is stable at the edge where the block samples it. Because the clock-high time is counted on the system clock, each ratio check stays exact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WORD_W    = 32;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + WORD_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int SEL_W     = 3;
    localparam int HALF_W    = 6;
    localparam int TA_POS    = 14;
    localparam int REL_IDX   = PRE_LEN + TA_POS;
    localparam int CAP_IDX   = PRE_LEN + WORD_W - DATA_W;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic [1:0]        sof;
        logic [1:0]        op;
        logic [4:0]        phy_ad;
        logic [4:0]        reg_ad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } phase_t;

    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    half_period = HALF_W'(4);
            3'd1:    half_period = HALF_W'(8);
            3'd2:    half_period = HALF_W'(16);
            3'd3:    half_period = HALF_W'(24);
            3'd4:    half_period = HALF_W'(32);
            default: half_period = HALF_W'(48);
        endcase
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half_q;
    logic              tc;

    assign tc       = run && (cnt == half_q - 1'b1);
    assign rise_stb = tc && !mdc;
    assign fall_stb = tc && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mdc    <= 1'b0;
            half_q <= half_period('0);
        end else if (!run) begin
            cnt    <= '0;
            mdc    <= 1'b0;
            half_q <= half_period(div_sel);
        end else if (tc) begin
            cnt    <= '0;
            mdc    <= ~mdc;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    AST_MDC_LOW_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);  // R10

    AST_HALF_HELD: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && !$stable(mdc) |-> $past(cnt) == half_q - 1'b1);  // R4

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mgmt_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic [WORD_W-1:0] word_q,
    output logic              mdio_o,
    output logic              mdio_oe
);

    phase_t            phase;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W:0]    nxt_idx;
    logic [WORD_W-1:0] shreg;
    logic [DATA_W-1:0] cap;
    logic              is_rd;
    logic              accept;
    logic              last_bit;
    mgmt_word_t        in_w;

    assign in_w     = mgmt_word_t'(wr_word);
    assign busy     = (phase != PH_IDLE);
    assign accept   = wr_en && mgmt_en && !busy;
    assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
    assign nxt_idx  = {1'b0, bit_idx} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            shreg   <= '0;
            cap     <= '0;
            is_rd   <= 1'b0;
            word_q  <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (busy && !mgmt_en) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (accept) begin
            phase   <= PH_PRE;
            bit_idx <= '0;
            shreg   <= wr_word;
            word_q  <= wr_word;
            is_rd   <= (in_w.op == OP_READ);
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (busy) begin
            if (rise_stb && is_rd && (bit_idx >= IDX_W'(CAP_IDX))) begin
                cap <= {cap[DATA_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (last_bit) begin
                    phase   <= PH_IDLE;
                    bit_idx <= '0;
                    mdio_o  <= 1'b0;
                    mdio_oe <= 1'b0;
                    if (is_rd) begin
                        word_q[DATA_W-1:0] <= cap;
                    end
                end else begin
                    bit_idx <= nxt_idx[IDX_W-1:0];
                    if (nxt_idx < (IDX_W+1)'(PRE_LEN)) begin
                        phase  <= PH_PRE;
                        mdio_o <= 1'b1;
                    end else begin
                        phase  <= PH_FRAME;
                        mdio_o <= shreg[WORD_W-1];
                        shreg  <= {shreg[WORD_W-2:0], 1'b0};
                    end
                    mdio_oe <= !(is_rd && (nxt_idx >= (IDX_W+1)'(REL_IDX)));
                end
            end
        end
    end

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (rst)
        busy && (bit_idx < IDX_W'(PRE_LEN)) |-> mdio_o && mdio_oe);  // R3

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        busy && is_rd && (bit_idx >= IDX_W'(REL_IDX)) |-> !mdio_oe);  // R6

    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        busy && !is_rd |-> mdio_oe);  // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));  // R4

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mgmt_en,
    input  logic [2:0]  div_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    output logic [31:0] mgmt_word,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic busy;
    logic run;
    logic rise_stb;
    logic fall_stb;

    assign run  = busy && mgmt_en;
    assign idle = !busy;

    mdio_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_sel  (div_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mgmt_en  (mgmt_en),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .word_q   (mgmt_word),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mdc && !mdio_oe);  // R10

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en && mgmt_en && idle |=> !idle);  // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mgmt_en |=> idle);  // R9

    AST_BUSY_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !idle |=> idle || $stable(mgmt_word));  // R8

endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] data;
        logic [2:0]  sel;
        logic [15:0] pd;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{op: 2'b01, phy: 5'd3,  ra: 5'd0,  data: 16'h1234, sel: 3'd0, pd: 16'h0000},
        '{op: 2'b10, phy: 5'd3,  ra: 5'd1,  data: 16'h0000, sel: 3'd1, pd: 16'hA5C3},
        '{op: 2'b10, phy: 5'd31, ra: 5'd31, data: 16'hFFFF, sel: 3'd2, pd: 16'h0001},
        '{op: 2'b01, phy: 5'd0,  ra: 5'd17, data: 16'h8001, sel: 3'd3, pd: 16'h0000},
        '{op: 2'b10, phy: 5'd9,  ra: 5'd4,  data: 16'h5A5A, sel: 3'd4, pd: 16'h8000},
        '{op: 2'b01, phy: 5'd21, ra: 5'd10, data: 16'hBEEF, sel: 3'd5, pd: 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        mgmt_en;
    logic [2:0]  div_sel;
    logic        wr_en;
    logic [31:0] wr_word;
    logic [31:0] mgmt_word;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int          checks   = 0;
    int          failures = 0;
    int          rc       = 0;
    int          hi_cnt   = 0;
    logic [63:0] got_o;
    logic [63:0] got_oe;
    logic [15:0] cur_pd   = 16'h0;

    always #10 clk = ~clk;

    mdio_master dut_i (
        .clk       (clk),
        .rst       (rst),
        .mgmt_en   (mgmt_en),
        .div_sel   (div_sel),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .mgmt_word (mgmt_word),
        .idle      (idle),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: reply bits change after a rising mdc edge, pull-up otherwise
    assign mdio_i = (rc >= 48 && rc < 64) ? cur_pd[63 - rc] : 1'b1;

    always @(posedge mdc) begin
        if (rc < 64) begin
            got_o[63 - rc]  = mdio_o;
            got_oe[63 - rc] = mdio_oe;
        end
        rc = rc + 1;
    end

    always @(posedge clk) if (mdc) hi_cnt = hi_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [2:0] s);
        case (s)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            default: return 96;
        endcase
    endfunction

    // Sends one word and checks timing, serial bits, drive enable and result.
    // inject: pulse wr_en with junk mid-frame (R8).
    task automatic run_frame(input logic [31:0] w, input logic [2:0] s, input logic [15:0] pd,
                             input bit inject, input string tag);
        int          n;
        int          cnt;
        bit          rd;
        logic [63:0] exp_o;
        logic [63:0] exp_oe;
        logic [31:0] exp_w;
        n      = ratio(s);
        rd     = (w[29:28] == 2'b10);
        exp_o  = {32'hFFFF_FFFF, w};
        exp_oe = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        exp_w  = rd ? {w[31:16], pd} : w;
        @(negedge clk);
        rc      = 0;
        hi_cnt  = 0;
        cur_pd  = pd;
        got_o   = '0;
        got_oe  = '0;
        div_sel = s;
        wr_word = w;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(!idle && mgmt_word == w, {"R2 accept ", tag}, {31'b0, idle}, 64'h0);
        cnt = 0;
        while (cnt < 8000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (inject && cnt == 50) begin
                wr_word = ~w;
                div_sel = 3'd0;
                wr_en   = 1'b1;
            end else if (inject && cnt == 51) begin
                wr_en = 1'b0;
            end
            if (idle) break;
        end
        div_sel = s;
        chk(cnt == 64 * n, {"R5 frame length ", tag}, 64'(cnt), 64'(64 * n));
        chk(hi_cnt == 32 * n, {"R4 mdc high time ", tag}, 64'(hi_cnt), 64'(32 * n));
        chk((got_o & exp_oe) == (exp_o & exp_oe), {"R3 serial bits ", tag}, got_o, exp_o);
        chk(got_oe == exp_oe, {rd ? "R6 drive enable " : "R7 drive enable ", tag}, got_oe, exp_oe);
        chk(mgmt_word == exp_w, {rd ? "R6 read word " : "R7 write word ", tag},
            64'(mgmt_word), 64'(exp_w));
        chk(!mdc && !mdio_oe, {"R10 quiet at end ", tag}, {62'b0, mdc, mdio_oe}, 64'h0);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] p,
                                       input logic [4:0] r, input logic [15:0] d);
        return {2'b01, op, p, r, 2'b10, d};
    endfunction

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        rst     = 1'b1;
        mgmt_en = 1'b1;
        div_sel = 3'd0;
        wr_en   = 1'b0;
        wr_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe && mgmt_word == 0, "R1 reset state",
            {mgmt_word, 29'b0, idle, mdc, mdio_oe}, 64'h4);
        rst = 1'b0;

        // table-driven frames: ratios 0..5, reads and writes (R3 R4 R5 R6 R7)
        for (int i = 0; i < NVEC; i++) begin
            run_frame(mk(VEC[i].op, VEC[i].phy, VEC[i].ra, VEC[i].data),
                      VEC[i].sel, VEC[i].pd, 1'b0, $sformatf("vec%0d", i));
        end

        // R4: select 7 falls back to ratio 96; op 11 treated as write (R7)
        run_frame(mk(2'b11, 5'd1, 5'd2, 16'h0F0F), 3'd7, 16'h0, 1'b0, "sel7");

        // R8: write during a read frame is ignored
        run_frame(mk(2'b10, 5'd7, 5'd5, 16'h0000), 3'd0, 16'h3C96, 1'b1, "busy write");

        // R9: disabled port ignores wr_en
        w = mgmt_word;
        @(negedge clk);
        mgmt_en = 1'b0;
        wr_word = 32'h1111_2222;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(idle && !mdc && mgmt_word == w, "R9 disabled write ignored",
            64'(mgmt_word), 64'(w));
        mgmt_en = 1'b1;

        // R9: abort mid-frame
        @(negedge clk);
        w       = mk(2'b10, 5'd2, 5'd3, 16'h7777);
        cur_pd  = 16'h0000;
        rc      = 0;
        div_sel = 3'd0;
        wr_word = w;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (101) @(negedge clk);
        chk(!idle && mdc, "R9 frame running before abort", {62'b0, idle, mdc}, 64'h1);
        mgmt_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe, "R9 abort quiet", {61'b0, idle, mdc, mdio_oe}, 64'h4);
        chk(mgmt_word == w, "R9 abort keeps word", 64'(mgmt_word), 64'(w));
        mgmt_en = 1'b1;

        // R2 again after abort: a new frame runs normally
        run_frame(mk(2'b01, 5'd4, 5'd6, 16'hC001), 3'd1, 16'h0, 1'b0, "after abort");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule